// File: doc/BRIEF.md
# Clock-Gated Prefix-Tree Magnitude Comparator

This block compares two unsigned operands, A and B, and reports whether A is greater than, equal to, or less than B. It does not use a subtractor or a ripple chain. Each two-bit slice of the operands is encoded into a pair of relation bits: "greater" and "equal". These bits play the same roles as generate and propagate in a fast adder. The pairs are combined in a logarithmic-depth merge tree. Only the root of the tree is kept, and it drives a set of three registered flags. The flags appear on the clock edge after the operands are sampled.

The most-significant bit pair is always encoded. The part of the tree that covers the lower bits is treated as a gated region. Its operand inputs are refreshed only when the top pair compares equal. At all other times, hold registers keep those inputs frozen, so the lower tree sees no switching activity. When the top pair differs, an output multiplexer takes the result from the top pair alone. The held, stale lower data therefore never reaches the flags.

Top module: `tcmp_tree_top`

## Requirements
- R1: One clock edge after A and B are sampled with `rst` low, `gt_o` is 1 exactly when A > B as unsigned 8-bit values.
- R2: One clock edge after sampling, `eq_o` is 1 exactly when A == B.
- R3: One clock edge after sampling, `lt_o` is 1 exactly when A < B. It equals NOT(`gt_o` OR `eq_o`).
- R4: After the first sampling edge with `rst` low, exactly one of `gt_o`, `eq_o` and `lt_o` is 1 in every cycle.
- R5: The reset is synchronous and active-high. On any edge where `rst` is 1, all three flags become 0, and they stay 0 while `rst` is held.
- R6: When bits [7:6] of A and B differ, the verdict follows those two bits alone. This holds for every value of bits [5:0].
- R7: While bits [7:6] of A and B differ, changes on bits [5:0] of either operand have no effect on the flags.
- R8: On the first cycle whose top pair compares equal, after any run of cycles where it differed, the flags reflect the current bits [5:0] and not values left over from earlier cycles.
- R9: The latency is exactly one cycle. Between two edges, the flags still show the pair sampled at the earlier edge, even after new operands have been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| gt_o | output | 1 | Registered flag: A greater than B |
| eq_o | output | 1 | Registered flag: A equal to B |
| lt_o | output | 1 | Registered flag: A less than B |

## Verification
The properties assume that `a_i` and `b_i` are settled and free of unknowns at every rising edge where `rst` is low. They also assume that reset is asserted from time zero until after the first edge. Under these assumptions, the one-hot, top-pair and equality properties hold from the first sample onward. The bench changes operands only on falling edges and holds `rst` high through the first few edges. It sweeps every one of the 65,536 operand pairs, one pair per cycle. Because the top pair flips between equal and unequal many times during the sweep, the hold registers of the gated region are exercised repeatedly.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    // Relation of one span of bits: gt = A greater over the span, eq = equal.
    typedef struct packed {
        logic gt;
        logic eq;
    } rel_t;

    // Registered verdict carried to the ports.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } verdict_t;

    // Identity element of the merge: an empty span is "equal".
    localparam rel_t REL_NEUTRAL = '{gt: 1'b0, eq: 1'b1};

    // Prefix merge: a more-significant span decides unless it is equal.
    function automatic rel_t rel_merge(input rel_t hi, input rel_t lo);
        rel_t r;
        r.gt = hi.gt | (hi.eq & lo.gt);
        r.eq = hi.eq & lo.eq;
        return r;
    endfunction

    // Leaf encoder for a two-bit slice.
    function automatic rel_t rel_pair(input logic [1:0] a, input logic [1:0] b);
        rel_t r;
        logic same_hi;
        same_hi = ~(a[1] ^ b[1]);
        r.gt    = (a[1] & ~b[1]) | (same_hi & a[0] & ~b[0]);
        r.eq    = same_hi & ~(a[0] ^ b[0]);
        return r;
    endfunction

    function automatic verdict_t to_verdict(input rel_t r);
        verdict_t v;
        v.gt = r.gt;
        v.eq = r.eq;
        v.lt = ~(r.gt | r.eq);
        return v;
    endfunction

endpackage

// File: rtl/tcmp_pair_enc.sv
module tcmp_pair_enc
    import tcmp_pkg::*;
#(
    parameter int NPAIR = 3
) (
    input  logic [2*NPAIR-1:0] a_i,
    input  logic [2*NPAIR-1:0] b_i,
    output rel_t [NPAIR-1:0]   leaf_o
);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign leaf_o[p] = rel_pair(a_i[2*p +: 2], b_i[2*p +: 2]);
    end

endmodule

// File: rtl/tcmp_merge_tree.sv
module tcmp_merge_tree
    import tcmp_pkg::*;
#(
    parameter int NLEAF = 3
) (
    input  rel_t [NLEAF-1:0] leaf_i,
    output rel_t             root_o
);

    localparam int LEVELS = (NLEAF > 1) ? $clog2(NLEAF) : 0;
    localparam int PADN   = 1 << LEVELS;

    // Higher index = more significant span at every level.
    rel_t [PADN-1:0] node [0:LEVELS];

    for (genvar i = 0; i < PADN; i++) begin : g_leaf
        if (i < NLEAF) begin : g_real
            assign node[0][i] = leaf_i[i];
        end else begin : g_pad
            assign node[0][i] = REL_NEUTRAL;
        end
    end

    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        for (genvar j = 0; j < PADN; j++) begin : g_node
            if (j < (PADN >> l)) begin : g_merge
                assign node[l][j] = rel_merge(node[l-1][2*j+1], node[l-1][2*j]);
            end else begin : g_unused
                assign node[l][j] = REL_NEUTRAL;
            end
        end
    end

    assign root_o = node[LEVELS][0];

    // R4: a span can never be both greater and equal.
    always_comb begin
        a_r4_root_exclusive: assert (!(root_o.gt && root_o.eq));
    end

endmodule

// File: rtl/tcmp_lo_isolate.sv
module tcmp_lo_isolate #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);

    logic [W-1:0] a_hold_q;
    logic [W-1:0] b_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_hold_q <= '0;
            b_hold_q <= '0;
        end else if (en_i) begin
            a_hold_q <= a_i;
            b_hold_q <= b_i;
        end
    end

    // Gated region sees live operands only when enabled.
    assign a_o = en_i ? a_i : a_hold_q;
    assign b_o = en_i ? b_i : b_hold_q;

    // R7: across consecutive disabled cycles the gated tree inputs do not toggle.
    a_r7_gated_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (en_i || ($stable(a_o) && $stable(b_o))));

endmodule

// File: rtl/tcmp_tree_top.sv
module tcmp_tree_top
    import tcmp_pkg::*;
#(
    parameter int WIDTH = 8   // even, at least 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             gt_o,
    output logic             eq_o,
    output logic             lt_o
);

    localparam int NPAIR = WIDTH / 2;
    localparam int NLOW  = NPAIR - 1;
    localparam int LOW_W = 2 * NLOW;

    rel_t               top_rel;
    logic               lo_en;
    logic [LOW_W-1:0]   lo_a;
    logic [LOW_W-1:0]   lo_b;
    rel_t [NLOW-1:0]    lo_leaf;
    rel_t               lo_rel;
    rel_t               final_rel;
    verdict_t           verdict_q;

    // Always-evaluated most-significant pair.
    assign top_rel = rel_pair(a_i[WIDTH-1 -: 2], b_i[WIDTH-1 -: 2]);
    assign lo_en   = top_rel.eq;

    tcmp_lo_isolate #(.W(LOW_W)) u_iso (
        .clk  (clk),
        .rst  (rst),
        .en_i (lo_en),
        .a_i  (a_i[LOW_W-1:0]),
        .b_i  (b_i[LOW_W-1:0]),
        .a_o  (lo_a),
        .b_o  (lo_b)
    );

    tcmp_pair_enc #(.NPAIR(NLOW)) u_enc (
        .a_i    (lo_a),
        .b_i    (lo_b),
        .leaf_o (lo_leaf)
    );

    tcmp_merge_tree #(.NLEAF(NLOW)) u_tree (
        .leaf_i (lo_leaf),
        .root_o (lo_rel)
    );

    // Root select: the gated result is used only when it was evaluated.
    assign final_rel = lo_en ? rel_merge(top_rel, lo_rel) : top_rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= to_verdict(final_rel);
        end
    end

    assign gt_o = verdict_q.gt;
    assign eq_o = verdict_q.eq;
    assign lt_o = verdict_q.lt;

    // R4: one flag set after each sampling edge out of reset.
    a_r4_flags_onehot: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $onehot({gt_o, eq_o, lt_o}));

    // R6: a greater top pair decides the result.
    a_r6_top_greater: assert property (@(posedge clk) disable iff (rst)
        (a_i[WIDTH-1 -: 2] > b_i[WIDTH-1 -: 2]) |=> gt_o);

    // R6: a smaller top pair decides the result.
    a_r6_top_less: assert property (@(posedge clk) disable iff (rst)
        (a_i[WIDTH-1 -: 2] < b_i[WIDTH-1 -: 2]) |=> lt_o);

    // R2: equal operands give the equal flag a cycle later.
    a_r2_equal: assert property (@(posedge clk) disable iff (rst)
        (a_i == b_i) |=> eq_o);

    // R1: full greater-than seen one cycle later.
    a_r1_greater: assert property (@(posedge clk) disable iff (rst)
        (a_i > b_i) |=> (gt_o && !lt_o));

endmodule

// File: tb/tcmp_tree_top_tb.sv
module tcmp_tree_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_drv = '0;
    logic [7:0] b_drv = '0;
    logic       gt, eq, lt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tcmp_tree_top #(.WIDTH(8)) u_dut (
        .clk  (clk),
        .rst  (rst),
        .a_i  (a_drv),
        .b_i  (b_drv),
        .gt_o (gt),
        .eq_o (eq),
        .lt_o (lt)
    );

    task automatic check_flags(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d flags(gt,eq,lt) actual=%b expected=%b",
                     req, a_drv, b_drv, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [7:0] a, input logic [7:0] b);
        return {a > b, a == b, a < b};
    endfunction

    // Called on a falling edge; returns on the next falling edge after checking.
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input string req);
        a_drv = a;
        b_drv = b;
        @(negedge clk);
        check_flags(req, {gt, eq, lt}, model(a, b));
    endtask

    task automatic sweep_one(input logic [7:0] a, input logic [7:0] b);
        logic [2:0] e;
        e = model(a, b);
        a_drv = a;
        b_drv = b;
        @(negedge clk);
        if (e[2])      check_flags("R1", {gt, eq, lt}, e);
        else if (e[1]) check_flags("R2", {gt, eq, lt}, e);
        else           check_flags("R3", {gt, eq, lt}, e);
        checks++;
        if (!$onehot({gt, eq, lt})) begin
            failures++;
            $display("FAIL R4 a=%0d b=%0d actual=%b expected=one-hot", a, b, {gt, eq, lt});
        end
    endtask

    initial begin
        // R5: flags cleared under reset.
        a_drv = 8'hF0; b_drv = 8'h0F;
        repeat (3) @(negedge clk);
        check_flags("R5", {gt, eq, lt}, 3'b000);
        rst = 1'b0;

        // R6: top pair differs, lower bits disagree with it.
        apply(8'hFF, 8'h7F, "R6");
        apply(8'h40, 8'h3F, "R6");
        apply(8'h3F, 8'h40, "R6");

        // R7: top pair differs; lower bits sweep, verdict must stay A>B.
        for (int k = 0; k < 64; k++) begin
            apply({2'b10, 6'(k)}, {2'b01, 6'(63 - k)}, "R7");
        end
        // R8: top equal right after; lower bits decide, not held data.
        apply(8'h81, 8'h82, "R8");
        apply({2'b11, 6'd5}, {2'b00, 6'd9}, "R7");
        apply(8'hC9, 8'hC5, "R8");
        apply(8'h05, 8'h05, "R8");

        // R9: new operands do not show before the next edge.
        apply(8'h10, 8'h20, "R9");
        a_drv = 8'h30; b_drv = 8'h20;
        #2;
        check_flags("R9", {gt, eq, lt}, 3'b001);
        @(negedge clk);
        check_flags("R9", {gt, eq, lt}, 3'b100);

        // R1 R2 R3 R4: every operand pair.
        for (int i = 0; i < 65536; i++) begin
            sweep_one(8'(i >> 8), 8'(i));
        end

        // R5: reset in mid-stream clears the flags.
        rst = 1'b1;
        a_drv = 8'h99; b_drv = 8'h11;
        @(negedge clk);
        check_flags("R5", {gt, eq, lt}, 3'b000);
        @(negedge clk);
        check_flags("R5", {gt, eq, lt}, 3'b000);
        rst = 1'b0;
        apply(8'h11, 8'h99, "R3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule